// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block drives the shared external bus of an 8-bit controller core. The core fetches code and moves data over one set of pins. The sequencer splits every machine cycle of twelve oscillator clocks into two halves of six clocks. In each half it produces an address-latch strobe, and for external code a program-read strobe. On the low port it places the address low byte during the latch strobe and write data after it. On the high port it places either the high address byte or the core's port-2 value.

The core presents a request that the sequencer samples on the edge that opens a machine cycle. The request is a code fetch or a data move: read or write, and 16-bit or 8-bit addressed. On the edge that opens the second half, a code cycle samples its fetch address again. A data cycle uses the whole machine cycle. It gives up one latch strobe and both program-read strobes, and instead drives a read or write strobe through the middle of the cycle. The byte read is captured where the read strobe ends. A mode input can silence the latch strobe in every cycle except data moves. A filter acts on the reset input so that only a reset held for two machine cycles takes effect.

Top module: `xbus_sequencer`

## Requirements
- R1: Phases are numbered 0 to 11 within a machine cycle, with phase 0 the first clock after the cycle opens. In a code cycle with `ale_off` low, `ale` is high during phases 0, 1, 6 and 7 and low otherwise. This gives one two-clock pulse every six clocks.
- R2: In a data cycle (read or write), `ale` is high during phases 0 and 1 only. The second pulse of the cycle is omitted.
- R3: In an external code cycle, `psen_n` is low during phases 3 to 5 and 9 to 11. In data cycles and in internal code cycles, `psen_n` stays high for the whole machine cycle.
- R4: A code fetch is external when `ext_sel_n` is low, or when the fetch address is at or above `INT_ROM_BYTES` (default 16384). Otherwise it is internal.
- R5: While `ale_off` is high, `ale` stays low in code cycles but still pulses in data cycles as R2 describes.
- R6: `lo_oe` is high and `lo_out` equals the address low byte in two cases: during phases 0, 1, 6 and 7 of an external code cycle, and during phases 0 and 1 of a data cycle. In a write cycle, `lo_oe` stays high with `lo_out` equal to the write data during phases 2 to 10. At all other times `lo_oe` is low and `lo_out` is 0.
- R7: `hi_out` carries the latched address high byte in external code cycles and in data cycles with `req_wide` high. At all other times, including 8-bit-addressed data cycles, it carries the present `p2_val`.
- R8: `rd_n` is low during phases 3 to 9 of a read cycle and high otherwise. `wr_n` is low during phases 3 to 9 of a write cycle and high otherwise. The two are never low together.
- R9: `rdata` takes the value of `lo_in` at the clock edge where `rd_n` returns high. It holds that value until the next read.
- R10: A reset takes effect on the 24th consecutive edge with `rst` high, and is held while `rst` stays high. A shorter high pulse has no effect on any output. Under reset, `ale`, `lo_oe` and `rdata` are 0, and `psen_n`, `rd_n` and `wr_n` are 1.
- R11: The request inputs are sampled on the edge that enters phase 0; the first edge after reset is released enters phase 0. On the edge that enters phase 6, only a code cycle samples `addr` and `ext_sel_n` again, and `req_data` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Active-high reset request, filtered |
| req_data | input | 1 | Machine cycle is an external data move |
| req_write | input | 1 | Data move writes (else reads) |
| req_wide | input | 1 | Data move uses a 16-bit address |
| ale_off | input | 1 | Suppress address latch strobe outside data moves |
| ext_sel_n | input | 1 | Low forces code fetches to the external bus |
| addr | input | 16 | Fetch or data address |
| p2_val | input | 8 | Port-2 register value |
| wdata | input | 8 | Write data |
| lo_in | input | 8 | Value read back from the low port pins |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | External program read strobe, active low |
| rd_n | output | 1 | External data read strobe, active low |
| wr_n | output | 1 | External data write strobe, active low |
| lo_out | output | 8 | Low port drive value |
| lo_oe | output | 1 | Low port output enable |
| hi_out | output | 8 | High port drive value |
| rdata | output | 8 | Captured read byte |

## Verification
On every cycle the assertions check the exclusions among strobes: read and write never low together, program read never low with either of them, and no latch strobe while program read is low. They also check that the low port is released during reads and driven during writes. Further per-cycle checks are that each latch pulse starts at phase 0 or 6, that the read byte tracks the pin value at the end of the read strobe, and that all strobes are inactive after an effective reset. Three behaviours depend on the requests and the mode inputs, and only the bench's scenarios show them: the number of latch and program-read pulses in each cycle kind, the choice between internal and external fetch at the address boundary, and the choice of high byte. The same holds for mid-cycle sampling and for a reset pulse that is too short to act.

// File: rtl/xbus_seq_pkg.sv
package xbus_seq_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        KIND_IDLE,
        KIND_CODE_INT,
        KIND_CODE_EXT,
        KIND_DATA_RD,
        KIND_DATA_WR
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        logic              wide;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } slot_t;

    function automatic logic is_data(kind_e k);
        return (k == KIND_DATA_RD) || (k == KIND_DATA_WR);
    endfunction

    function automatic kind_e code_kind(logic ext_sel_n,
                                        logic [ADDR_W-1:0] a,
                                        logic [ADDR_W:0] rom_lim);
        return (!ext_sel_n || ({1'b0, a} >= rom_lim)) ? KIND_CODE_EXT : KIND_CODE_INT;
    endfunction

endpackage

// File: rtl/xbus_rst_filter.sv
module xbus_rst_filter #(
    parameter int HOLD = 24
) (
    input  logic clk,
    input  logic rst,
    output logic core_rst
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] C_MAX  = CW'(HOLD);
    localparam logic [CW-1:0] C_FIRE = CW'(HOLD - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst)
            cnt <= '0;
        else if (cnt != C_MAX)
            cnt <= cnt + 1'b1;
    end

    assign core_rst = rst && (cnt >= C_FIRE);
endmodule

// File: rtl/xbus_phase_ctr.sv
module xbus_phase_ctr #(
    parameter int HALF = 6,
    localparam int PH_W = $clog2(2 * HALF)
) (
    input  logic            clk,
    input  logic            core_rst,
    output logic [PH_W-1:0] phase,
    output logic            open_first,
    output logic            open_second
);
    localparam logic [PH_W-1:0] P_LAST = PH_W'(2 * HALF - 1);
    localparam logic [PH_W-1:0] P_MID  = PH_W'(HALF - 1);

    always_ff @(posedge clk) begin
        if (core_rst)
            phase <= P_LAST;
        else if (phase == P_LAST)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    assign open_first  = (phase == P_LAST);
    assign open_second = (phase == P_MID);
endmodule

// File: rtl/xbus_slot_latch.sv
module xbus_slot_latch
    import xbus_seq_pkg::*;
#(
    parameter int ROM_BYTES = 16384
) (
    input  logic              clk,
    input  logic              core_rst,
    input  logic              open_first,
    input  logic              open_second,
    input  logic              req_data,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic              ext_sel_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output slot_t             slot
);
    localparam logic [ADDR_W:0] ROM_LIM = (ADDR_W + 1)'(ROM_BYTES);

    slot_t fresh;

    always_comb begin
        fresh.wide  = req_wide;
        fresh.addr  = addr;
        fresh.wdata = wdata;
        if (req_data)
            fresh.kind = req_write ? KIND_DATA_WR : KIND_DATA_RD;
        else
            fresh.kind = code_kind(ext_sel_n, addr, ROM_LIM);
    end

    always_ff @(posedge clk) begin
        if (core_rst) begin
            slot.kind  <= KIND_IDLE;
            slot.wide  <= 1'b0;
            slot.addr  <= '0;
            slot.wdata <= '0;
        end else if (open_first) begin
            slot <= fresh;
        end else if (open_second && !is_data(slot.kind)) begin
            slot.kind <= code_kind(ext_sel_n, addr, ROM_LIM);
            slot.addr <= addr;
        end
    end
endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
    import xbus_seq_pkg::*;
#(
    parameter int HALF = 6,
    localparam int PH_W = $clog2(2 * HALF)
) (
    input  logic [PH_W-1:0]   phase,
    input  slot_t             slot,
    input  logic              ale_off,
    input  logic [DATA_W-1:0] p2_val,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] lo_out,
    output logic              lo_oe,
    output logic [DATA_W-1:0] hi_out,
    output logic              rd_capture
);
    localparam logic [PH_W-1:0] P_HALF    = PH_W'(HALF);
    localparam logic [PH_W-1:0] ALE_LEN   = PH_W'(HALF / 3);
    localparam logic [PH_W-1:0] PS_START  = PH_W'(HALF / 2);
    localparam logic [PH_W-1:0] DS_START  = PH_W'(HALF / 2);
    localparam logic [PH_W-1:0] DS_END    = PH_W'(2 * HALF - HALF / 2);
    localparam logic [PH_W-1:0] WD_END    = PH_W'(2 * HALF - HALF / 3);

    logic [PH_W-1:0] ofs;
    logic            second;
    logic            in_ale_slot;
    logic            data_mid;
    logic            show_addr_lo;
    logic            show_wdata;

    always_comb begin
        second      = (phase >= P_HALF);
        ofs         = second ? (phase - P_HALF) : phase;
        in_ale_slot = (ofs < ALE_LEN);
        data_mid    = (phase >= DS_START) && (phase <= DS_END);

        unique case (slot.kind)
            KIND_CODE_INT, KIND_CODE_EXT: ale = in_ale_slot && !ale_off;
            KIND_DATA_RD, KIND_DATA_WR:   ale = in_ale_slot && !second;
            default:                      ale = 1'b0;
        endcase

        psen_n = !((slot.kind == KIND_CODE_EXT) && (ofs >= PS_START));
        rd_n   = !((slot.kind == KIND_DATA_RD) && data_mid);
        wr_n   = !((slot.kind == KIND_DATA_WR) && data_mid);

        show_addr_lo = ((slot.kind == KIND_CODE_EXT) && in_ale_slot) ||
                       (is_data(slot.kind) && (phase < ALE_LEN));
        show_wdata   = (slot.kind == KIND_DATA_WR) && (phase >= ALE_LEN) && (phase <= WD_END);

        lo_oe = show_addr_lo || show_wdata;
        if (show_addr_lo)
            lo_out = slot.addr[DATA_W-1:0];
        else if (show_wdata)
            lo_out = slot.wdata;
        else
            lo_out = '0;

        if ((slot.kind == KIND_CODE_EXT) || (is_data(slot.kind) && slot.wide))
            hi_out = slot.addr[ADDR_W-1:DATA_W];
        else
            hi_out = p2_val;

        rd_capture = (slot.kind == KIND_DATA_RD) && (phase == DS_END);
    end
endmodule

// File: rtl/xbus_sequencer.sv
module xbus_sequencer
    import xbus_seq_pkg::*;
#(
    parameter int INT_ROM_BYTES = 16384,
    parameter int HALF_CLKS     = 6,
    parameter int RST_HOLD      = 4 * HALF_CLKS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_data,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic              ale_off,
    input  logic              ext_sel_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] p2_val,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] lo_in,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] lo_out,
    output logic              lo_oe,
    output logic [DATA_W-1:0] hi_out,
    output logic [DATA_W-1:0] rdata
);
    localparam int PH_W = $clog2(2 * HALF_CLKS);

    logic            core_rst;
    logic [PH_W-1:0] phase;
    logic            open_first;
    logic            open_second;
    slot_t           slot;
    logic            rd_capture;

    xbus_rst_filter #(.HOLD(RST_HOLD)) u_rst (
        .clk      (clk),
        .rst      (rst),
        .core_rst (core_rst)
    );

    xbus_phase_ctr #(.HALF(HALF_CLKS)) u_phase (
        .clk         (clk),
        .core_rst    (core_rst),
        .phase       (phase),
        .open_first  (open_first),
        .open_second (open_second)
    );

    xbus_slot_latch #(.ROM_BYTES(INT_ROM_BYTES)) u_slot (
        .clk         (clk),
        .core_rst    (core_rst),
        .open_first  (open_first),
        .open_second (open_second),
        .req_data    (req_data),
        .req_write   (req_write),
        .req_wide    (req_wide),
        .ext_sel_n   (ext_sel_n),
        .addr        (addr),
        .wdata       (wdata),
        .slot        (slot)
    );

    xbus_strobe_gen #(.HALF(HALF_CLKS)) u_strobe (
        .phase      (phase),
        .slot       (slot),
        .ale_off    (ale_off),
        .p2_val     (p2_val),
        .ale        (ale),
        .psen_n     (psen_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .lo_out     (lo_out),
        .lo_oe      (lo_oe),
        .hi_out     (hi_out),
        .rd_capture (rd_capture)
    );

    always_ff @(posedge clk) begin
        if (core_rst)
            rdata <= '0;
        else if (rd_capture)
            rdata <= lo_in;
    end
endmodule

// File: rtl/xbus_seq_checks.sv
module xbus_seq_checks #(
    parameter int HALF = 6,
    localparam int PH_W = $clog2(2 * HALF)
) (
    input logic            clk,
    input logic            rst,
    input logic            core_rst,
    input logic [PH_W-1:0] phase,
    input logic            ale,
    input logic            psen_n,
    input logic            rd_n,
    input logic            wr_n,
    input logic            lo_oe,
    input logic [7:0]      lo_in,
    input logic [7:0]      rdata
);
    localparam logic [PH_W-1:0] P_HALF = PH_W'(HALF);

    logic armed = 1'b0;

    always_ff @(posedge clk) begin
        if (core_rst)
            armed <= 1'b1;
    end

    assert_rw_exclusive_R8: assert property (@(posedge clk) disable iff (!armed || rst)
        !(!rd_n && !wr_n));

    assert_no_psen_in_data_R3: assert property (@(posedge clk) disable iff (!armed || rst)
        !psen_n |-> (rd_n && wr_n));

    assert_ale_outside_psen_R1: assert property (@(posedge clk) disable iff (!armed || rst)
        ale |-> psen_n);

    assert_bus_free_on_read_R6: assert property (@(posedge clk) disable iff (!armed || rst)
        !rd_n |-> !lo_oe);

    assert_bus_driven_on_write_R6: assert property (@(posedge clk) disable iff (!armed || rst)
        !wr_n |-> lo_oe);

    assert_ale_slot_start_R1: assert property (@(posedge clk) disable iff (!armed || rst)
        $rose(ale) |-> ((phase == '0) || (phase == P_HALF)));

    assert_read_capture_R9: assert property (@(posedge clk) disable iff (!armed || rst)
        $rose(rd_n) |-> (rdata == $past(lo_in)));

    assert_reset_quiet_R10: assert property (@(posedge clk) disable iff (!armed)
        core_rst |=> (!ale && psen_n && rd_n && wr_n && !lo_oe && (rdata == 8'h00)));
endmodule

bind xbus_sequencer xbus_seq_checks #(.HALF(HALF_CLKS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .core_rst (core_rst),
    .phase    (phase),
    .ale      (ale),
    .psen_n   (psen_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .lo_oe    (lo_oe),
    .lo_in    (lo_in),
    .rdata    (rdata)
);

// File: tb/sim_xbus_sequencer.sv
module sim_xbus_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b0;
    logic        req_data = 1'b0, req_write = 1'b0, req_wide = 1'b0;
    logic        ale_off = 1'b0, ext_sel_n = 1'b1;
    logic [15:0] addr = 16'h0;
    logic [7:0]  p2_val = 8'h00, wdata = 8'h00, lo_in = 8'h5A;
    logic        ale, psen_n, rd_n, wr_n, lo_oe;
    logic [7:0]  lo_out, hi_out, rdata;

    int compared = 0;
    int mismatched = 0;

    // reference state
    int   m_phase = 11, m_kind = 0, r_cnt = 0;
    logic m_seen = 1'b0;
    logic [15:0] m_addr = 0;
    logic m_wide = 0;
    logic [7:0] m_wdata = 0, m_rdata = 0;
    int   n_ale_hi, n_psen_lo;

    always #4 clk = ~clk;

    xbus_sequencer u0 (
        .clk(clk), .rst(rst), .req_data(req_data), .req_write(req_write),
        .req_wide(req_wide), .ale_off(ale_off), .ext_sel_n(ext_sel_n),
        .addr(addr), .p2_val(p2_val), .wdata(wdata), .lo_in(lo_in),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .lo_out(lo_out), .lo_oe(lo_oe), .hi_out(hi_out), .rdata(rdata)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // 0 idle, 1 internal code, 2 external code, 3 read, 4 write
    function automatic int code_kind_of(logic esn, logic [15:0] a);
        return (!esn || a >= 16'h4000) ? 2 : 1;
    endfunction

    task automatic model_edge(input logic s_rst, input logic s_data, input logic s_wr,
                              input logic s_wide, input logic s_esn, input logic [15:0] s_addr,
                              input logic [7:0] s_wdata, input logic [7:0] s_lo);
        if (s_rst && r_cnt >= 23) begin
            m_phase = 11; m_kind = 0; m_rdata = 0; m_addr = 0; m_wide = 0; m_wdata = 0;
            m_seen = 1'b1;
        end else begin
            if (m_phase == 9 && m_kind == 3) m_rdata = s_lo;
            if (m_phase == 11) begin
                m_phase = 0;
                m_addr = s_addr; m_wide = s_wide; m_wdata = s_wdata;
                m_kind = s_data ? (s_wr ? 4 : 3) : code_kind_of(s_esn, s_addr);
            end else if (m_phase == 5) begin
                m_phase = 6;
                if (m_kind != 3 && m_kind != 4) begin
                    m_addr = s_addr;
                    m_kind = code_kind_of(s_esn, s_addr);
                end
            end else begin
                m_phase++;
            end
        end
        r_cnt = s_rst ? ((r_cnt < 24) ? r_cnt + 1 : 24) : 0;
    endtask

    task automatic compare_outputs();
        int o = m_phase % 6;
        logic sec = (m_phase >= 6);
        logic dat = (m_kind == 3 || m_kind == 4);
        logic e_ale, e_psen, e_rd, e_wr, e_oe, adr_lo;
        logic [7:0] e_lo, e_hi;
        e_ale  = (m_kind == 1 || m_kind == 2) ? (o < 2 && !ale_off) : (dat ? (o < 2 && !sec) : 1'b0);
        e_psen = !(m_kind == 2 && o >= 3);
        e_rd   = !(m_kind == 3 && m_phase >= 3 && m_phase <= 9);
        e_wr   = !(m_kind == 4 && m_phase >= 3 && m_phase <= 9);
        adr_lo = (m_kind == 2 && o < 2) || (dat && m_phase < 2);
        e_oe   = adr_lo || (m_kind == 4 && m_phase >= 2 && m_phase <= 10);
        e_lo   = adr_lo ? m_addr[7:0] : (e_oe ? m_wdata : 8'h00);
        e_hi   = (m_kind == 2 || (dat && m_wide)) ? m_addr[15:8] : p2_val;
        check(ale === e_ale, "R1/R2/R5 ale", ale, e_ale);
        check(psen_n === e_psen, "R3/R4 psen_n", psen_n, e_psen);
        check(rd_n === e_rd, "R8 rd_n", rd_n, e_rd);
        check(wr_n === e_wr, "R8 wr_n", wr_n, e_wr);
        check(lo_oe === e_oe, "R6 lo_oe", lo_oe, e_oe);
        check(lo_out === e_lo, "R6 lo_out", lo_out, e_lo);
        check(hi_out === e_hi, "R7 hi_out", hi_out, e_hi);
        check(rdata === m_rdata, "R9 rdata", rdata, m_rdata);
    endtask

    task automatic step();
        logic s_rst = rst, s_data = req_data, s_wr = req_write, s_wide = req_wide, s_esn = ext_sel_n;
        logic [15:0] s_addr = addr;
        logic [7:0] s_wdata = wdata, s_lo = lo_in;
        @(posedge clk);
        model_edge(s_rst, s_data, s_wr, s_wide, s_esn, s_addr, s_wdata, s_lo);
        #1;
        if (m_seen) compare_outputs();
        if (ale === 1'b1) n_ale_hi++;
        if (psen_n === 1'b0) n_psen_lo++;
        lo_in = {lo_in[6:0], lo_in[7] ^ lo_in[5] ^ lo_in[4] ^ lo_in[3]};
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic mc(input logic d, input logic w, input logic wd, input logic esn,
                      input logic aoff, input logic [15:0] a, input logic [7:0] wv,
                      input logic [7:0] p2);
        req_data = d; req_write = w; req_wide = wd; ext_sel_n = esn;
        ale_off = aoff; addr = a; wdata = wv; p2_val = p2;
        n_ale_hi = 0; n_psen_lo = 0;
        steps(12);
    endtask

    initial begin
        #(8 * 200000);
        mismatched++;
        $display("FAIL watchdog: run did not finish (all requirements)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        steps(2);
        rst = 1'b1;
        steps(26);
        // R10 reset state
        check(ale === 1'b0 && psen_n === 1'b1 && rd_n === 1'b1 && wr_n === 1'b1 && lo_oe === 1'b0,
              "R10 reset state", {ale, psen_n, rd_n, wr_n, lo_oe}, 5'b01110);
        rst = 1'b0;

        // R1 R3: external code, two pulses of each strobe
        mc(0, 0, 0, 0, 0, 16'h1234, 8'h00, 8'hC3);
        check(n_ale_hi == 4, "R1 ale clocks per code cycle", n_ale_hi, 4);
        check(n_psen_lo == 6, "R3 psen clocks per ext code cycle", n_psen_lo, 6);
        // R4: internal fetch below boundary
        mc(0, 0, 0, 1, 0, 16'h3FFF, 8'h00, 8'h11);
        check(n_psen_lo == 0, "R4 internal fetch psen", n_psen_lo, 0);
        check(n_ale_hi == 4, "R1 ale on internal fetch", n_ale_hi, 4);
        // R4: boundary address goes external
        mc(0, 0, 0, 1, 0, 16'h4000, 8'h00, 8'h22);
        check(n_psen_lo == 6, "R4 boundary fetch external", n_psen_lo, 6);
        // R2 R3 R7: wide read
        mc(1, 0, 1, 1, 0, 16'hA55A, 8'h00, 8'h33);
        check(n_ale_hi == 2, "R2 ale in data cycle", n_ale_hi, 2);
        check(n_psen_lo == 0, "R3 psen omitted in data cycle", n_psen_lo, 0);
        check(rdata === m_rdata, "R9 captured read byte", rdata, m_rdata);
        // R7 R6: narrow write with p2 on high port
        mc(1, 1, 0, 0, 0, 16'hBEEF, 8'h96, 8'h3C);
        check(n_ale_hi == 2, "R2 ale in write cycle", n_ale_hi, 2);
        // R5: ale_off silences code ALE, keeps data ALE
        mc(0, 0, 0, 0, 1, 16'h0042, 8'h00, 8'h44);
        check(n_ale_hi == 0, "R5 ale off in code cycle", n_ale_hi, 0);
        check(n_psen_lo == 6, "R5 psen unaffected", n_psen_lo, 6);
        mc(1, 0, 0, 0, 1, 16'h7781, 8'h00, 8'h55);
        check(n_ale_hi == 2, "R5 ale kept in data cycle", n_ale_hi, 2);

        // R11: data request raised mid-cycle is ignored; second fetch resamples addr
        req_data = 0; ext_sel_n = 1; ale_off = 0; addr = 16'h0100; p2_val = 8'h66;
        n_ale_hi = 0; n_psen_lo = 0;
        steps(3);
        req_data = 1; req_write = 1; addr = 16'h9A00;
        steps(9);
        check(n_psen_lo == 3, "R11 mid-cycle req ignored, second half external", n_psen_lo, 3);
        check(hi_out === 8'h9A, "R11 second half address high byte", hi_out, 8'h9A);

        // R10: pulse of 23 edges has no effect
        mc(0, 0, 0, 0, 0, 16'h2468, 8'h00, 8'h77);
        req_data = 0; ext_sel_n = 0; addr = 16'h1357;
        n_ale_hi = 0; n_psen_lo = 0;
        rst = 1'b1;
        steps(23);
        rst = 1'b0;
        steps(1);
        check(n_ale_hi == 8, "R10 short reset ignored (ale)", n_ale_hi, 8);
        check(n_psen_lo == 12, "R10 short reset ignored (psen)", n_psen_lo, 12);

        // mixed traffic
        for (int k = 0; k < 24; k++) begin
            logic [15:0] a = 16'(k * 16'h2F3B + 16'h0107);
            mc(k % 3 != 0, k % 2 == 1, k % 4 < 2, k % 5 == 0, k % 7 == 3, a,
               8'(k * 37 + 5), 8'(k * 11));
        end

        // R10: long reset in the middle of a read
        req_data = 1; req_write = 0; addr = 16'hC0DE;
        steps(5);
        rst = 1'b1;
        steps(30);
        check(ale === 1'b0 && psen_n === 1'b1 && rd_n === 1'b1 && wr_n === 1'b1 &&
              lo_oe === 1'b0 && rdata === 8'h00,
              "R10 strobes inactive after reset", {ale, psen_n, rd_n, wr_n, lo_oe}, 5'b01110);
        rst = 1'b0;
        mc(1, 0, 1, 0, 0, 16'h5EED, 8'h00, 8'h88);
        check(n_ale_hi == 2, "R10 first cycle after reset aligned", n_ale_hi, 2);
        mc(0, 0, 0, 0, 0, 16'h0F0F, 8'h00, 8'h99);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule